// File: doc/BRIEF.md
# Push-Pull PWM Generator with Deadtime

This block is a digital fixed-frequency pulse width modulator for a switching power stage. A free-running up-counter (the ramp) counts from zero to a programmable period value and then wraps, so one ramp cycle lasts period+1 clocks. A drive pulse is on only while the ramp is strictly above every threshold in force. There are two thresholds. The first is the larger of two error-control words. The second is a deadtime word plus a built-in minimum deadtime derived from the period. Raising either control word, or the deadtime word, therefore shortens the pulse linearly. The control word that asks for the shorter on-time always sets the pulse width.

A steering toggle flips at each ramp wrap. In push-pull mode it sends successive pulses to output A and output B in turn, so each output runs at half the ramp rate and the two outputs are never on together. In single-ended mode the toggle is held clear and both outputs carry the same pulse in every ramp cycle. The control words, deadtime word, period and mode are all captured at period start, so a change in the middle of a period cannot cut a pulse short. A one-cycle strobe marks the start of each period.

Top module: `push_pull_pwm`

## Requirements
- R1: The ramp runs from 0 to the captured period P and wraps. A period therefore lasts P+1 clocks. `period_start` is high for exactly one cycle per period.
- R2: The on-time of a period, counted in clocks, is max(0, P - T), where T = max(ctl_a, ctl_b, dead + M). An output is on only while the ramp is strictly greater than T.
- R3: Of the two control words, the larger one sets the pulse width. Swapping the values of `ctl_a` and `ctl_b` leaves the output unchanged.
- R4: The minimum deadtime M equals ceil(4*P/100), and is never less than 1. With all control and deadtime words at zero, the output is still blanked for M+1 clocks of each period. For example, P=99 gives an on-time of 95 clocks, and P=49 gives 47 clocks.
- R5: A deadtime word of all ones forces zero duty cycle on both outputs.
- R6: Push-pull mode (`single_mode`=0) works as follows. The first period after enable drives output A. Later periods alternate B, A, B and so on. The other output stays off for the whole period, and A and B are never high in the same cycle.
- R7: In single-ended mode (`single_mode`=1), both outputs carry the same pulse in every period. Each output has the full on-time from R2.
- R8: The words `ctl_a`, `ctl_b`, `dead` and `period`, and the mode, are captured when the ramp wraps. A change made during a period takes effect only in the following period.
- R9: While `rst` is high or `en` is low, the ramp is held at 0, the steering toggle is cleared, and both outputs and the strobe are low.
- R10: In the cycle where `period_start` is high, both outputs are low. This is the blanking that starts each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block idle |
| single_mode | input | 1 | 1 = single-ended, 0 = push-pull |
| ctl_a | input | CNT_W | First error-control word |
| ctl_b | input | CNT_W | Second error-control word |
| dead | input | CNT_W | Extra deadtime word |
| period | input | CNT_W | Ramp terminal count P |
| drive_a | output | 1 | Drive output A (registered) |
| drive_b | output | 1 | Drive output B (registered) |
| period_start | output | 1 | One-cycle strobe at the start of each period (registered) |

## Verification
All three outputs come from one register stage after the ramp. As a result, `period_start` and the drive values that belong to ramp value 0 appear in the same cycle. The cycle after `en` rises already shows the first strobe. The bench frames each period from one strobe to the next. In each frame it counts the clocks and the high cycles of A and B, all sampled on the falling edge. It compares these counts with the P+1 and max(0, P-T) figures that it computes itself. A word written during a frame is checked against the frame that follows, because the capture happens at the wrap edge that closes the current frame.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    MODE_PUSHPULL = 1'b0,
    MODE_SINGLE   = 1'b1
  } drive_mode_e;

  localparam int MIN_DEAD_NUM = 4;
  localparam int MIN_DEAD_DEN = 100;
endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period_s,
  output logic [CNT_W-1:0] ramp,
  output logic             wrap,
  output logic             start_q
);
  assign wrap = run && (ramp == period_s);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ramp    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= (ramp == '0);
      if (wrap) ramp <= '0;
      else      ramp <= ramp + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             load,
  input  logic             single_mode,
  input  logic [CNT_W-1:0] ctl_a,
  input  logic [CNT_W-1:0] ctl_b,
  input  logic [CNT_W-1:0] dead,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] ctl_thr,
  output logic [CNT_W:0]   dead_thr,
  output logic [CNT_W-1:0] period_s,
  output drive_mode_e      mode_s
);
  localparam int PW = CNT_W + 8;

  logic [PW-1:0]    scaled;
  logic [CNT_W-1:0] min_dead;
  logic [CNT_W-1:0] ctl_max;

  // ceil(period * num / den), floor of one clock
  always_comb begin
    scaled   = ({8'd0, period} * PW'(MIN_DEAD_NUM) + PW'(MIN_DEAD_DEN - 1)) / PW'(MIN_DEAD_DEN);
    min_dead = (scaled == '0) ? CNT_W'(1) : scaled[CNT_W-1:0];
    ctl_max  = (ctl_a > ctl_b) ? ctl_a : ctl_b;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      ctl_thr  <= ctl_max;
      dead_thr <= {1'b0, dead} + {1'b0, min_dead};
      period_s <= period;
      mode_s   <= single_mode ? MODE_SINGLE : MODE_PUSHPULL;
    end
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wrap,
  input  drive_mode_e      mode_s,
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] ctl_thr,
  input  logic [CNT_W:0]   dead_thr,
  output logic             drive_a,
  output logic             drive_b
);
  logic tog;
  logic pulse_on;
  logic single;

  assign single   = (mode_s == MODE_SINGLE);
  assign pulse_on = (ramp > ctl_thr) && ({1'b0, ramp} > dead_thr);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      tog     <= 1'b0;
      drive_a <= 1'b0;
      drive_b <= 1'b0;
    end else begin
      if (wrap) tog <= single ? 1'b0 : ~tog;
      drive_a <= pulse_on && (single || !tog);
      drive_b <= pulse_on && (single || tog);
    end
  end
endmodule

// File: rtl/push_pull_pwm.sv
module push_pull_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             single_mode,
  input  logic [CNT_W-1:0] ctl_a,
  input  logic [CNT_W-1:0] ctl_b,
  input  logic [CNT_W-1:0] dead,
  input  logic [CNT_W-1:0] period,
  output logic             drive_a,
  output logic             drive_b,
  output logic             period_start
);
  logic [CNT_W-1:0] ramp;
  logic [CNT_W-1:0] period_s;
  logic [CNT_W-1:0] ctl_thr;
  logic [CNT_W:0]   dead_thr;
  drive_mode_e      mode_s;
  logic             wrap;
  logic             load;

  assign load = rst || !en || wrap;

  pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst(rst), .run(en), .period_s(period_s),
    .ramp(ramp), .wrap(wrap), .start_q(period_start)
  );

  pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .load(load), .single_mode(single_mode),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .dead(dead), .period(period),
    .ctl_thr(ctl_thr), .dead_thr(dead_thr), .period_s(period_s), .mode_s(mode_s)
  );

  pwm_steer #(.CNT_W(CNT_W)) u_steer (
    .clk(clk), .rst(rst), .run(en), .wrap(wrap), .mode_s(mode_s),
    .ramp(ramp), .ctl_thr(ctl_thr), .dead_thr(dead_thr),
    .drive_a(drive_a), .drive_b(drive_b)
  );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             drive_a,
  input logic             drive_b,
  input logic             period_start,
  input logic [CNT_W-1:0] ramp,
  input logic [CNT_W-1:0] period_s,
  input drive_mode_e      mode_s
);
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    (drive_a && drive_b) |-> ($past(mode_s) == MODE_SINGLE));

  assert_blank_at_start_R10: assert property (@(posedge clk) disable iff (rst)
    period_start |-> (!drive_a && !drive_b));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!drive_a && !drive_b && !period_start));

  assert_ramp_bound_R1: assert property (@(posedge clk) disable iff (rst)
    ramp <= period_s);
endmodule

bind push_pull_pwm pwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .drive_a(drive_a), .drive_b(drive_b),
  .period_start(period_start), .ramp(ramp), .period_s(period_s), .mode_s(mode_s)
);

// File: tb/push_pull_pwm_bench.sv
module push_pull_pwm_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic single_mode = 1'b0;
  logic [CNT_W-1:0] ctl_a = '0, ctl_b = '0, dead = '0, period = 16'd20;
  logic drive_a, drive_b, period_start;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  push_pull_pwm #(.CNT_W(CNT_W)) u_push_pull_pwm (
    .clk(clk), .rst(rst), .en(en), .single_mode(single_mode),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .dead(dead), .period(period),
    .drive_a(drive_a), .drive_b(drive_b), .period_start(period_start)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R1 watchdog expired: actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_on(int p, int ca, int cb, int dt);
    int md, t;
    md = (4 * p + 99) / 100;
    if (md == 0) md = 1;
    t = dt + md;
    if (ca > t) t = ca;
    if (cb > t) t = cb;
    return (p > t) ? p - t : 0;
  endfunction

  // idle, load words, enable, stop at the negedge showing the first strobe
  task automatic start(input int p, input int ca, input int cb, input int dt, input bit sm);
    int guard;
    @(negedge clk);
    en = 1'b0;
    period = CNT_W'(p); ctl_a = CNT_W'(ca); ctl_b = CNT_W'(cb); dead = CNT_W'(dt);
    single_mode = sm;
    repeat (3) @(negedge clk);
    en = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!period_start && guard < 70000);
  endtask

  // from a strobe negedge to the next strobe negedge
  task automatic measure(output int n, output int a, output int b);
    n = 0; a = 0; b = 0;
    do begin
      if (drive_a) a++;
      if (drive_b) b++;
      n++;
      @(negedge clk);
    end while (!period_start && n < 70000);
  endtask

  task automatic run_cfg(input int p, input int ca, input int cb, input int dt,
                         input bit sm, input int nper, input string tag);
    int n, a, b, e;
    e = exp_on(p, ca, cb, dt);
    start(p, ca, cb, dt, sm);
    for (int k = 0; k < nper; k++) begin
      measure(n, a, b);
      check(n == p + 1, {"R1 period length ", tag}, n, p + 1);
      if (sm) begin
        check(a == e, {"R7 single A ", tag}, a, e);
        check(b == e, {"R7 single B ", tag}, b, e);
      end else if (k % 2 == 0) begin
        check(a == e, {"R2 R6 push-pull A turn ", tag}, a, e);
        check(b == 0, {"R6 B idle on A turn ", tag}, b, 0);
      end else begin
        check(b == e, {"R2 R6 push-pull B turn ", tag}, b, e);
        check(a == 0, {"R6 A idle on B turn ", tag}, a, 0);
      end
    end
  endtask

  initial begin
    int n, a, b, busy;
    void'($urandom(32'd20240611));

    // R9: reset state
    repeat (4) @(negedge clk);
    check(!drive_a && !drive_b && !period_start, "R9 reset state", {drive_a, drive_b, period_start}, 0);
    rst = 1'b0;

    // R9: disabled block stays quiet
    busy = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (drive_a || drive_b || period_start) busy++;
    end
    check(busy == 0, "R9 idle while en low", busy, 0);

    // R2 R6 directed push-pull
    run_cfg(40, 10, 0, 0, 1'b0, 4, "p40 ca10");
    // R3: larger control dominates, either order
    run_cfg(30, 20, 5, 0, 1'b0, 2, "R3 ca>cb");
    run_cfg(30, 5, 20, 0, 1'b0, 2, "R3 cb>ca");
    // R4: minimum deadtime with zero words
    run_cfg(99, 0, 0, 0, 1'b1, 2, "R4 p99");
    run_cfg(49, 0, 0, 0, 1'b1, 2, "R4 p49");
    run_cfg(1, 0, 0, 0, 1'b1, 2, "R4 p1");
    // R5: full-scale deadtime kills output
    run_cfg(30, 0, 0, 16'hFFFF, 1'b1, 2, "R5 dead max");
    run_cfg(30, 0, 0, 16'hFFFF, 1'b0, 2, "R5 dead max pp");
    // extra deadtime word
    run_cfg(50, 3, 0, 12, 1'b0, 2, "R2 dead12");

    // R8: change mid-period applies to next period only
    start(40, 10, 0, 0, 1'b0);
    measure(n, a, b);
    check(a == 30, "R8 first period A", a, 30);
    repeat (5) @(negedge clk);
    ctl_a = 16'd30;
    n = 5; a = 0; b = 0;
    do begin
      if (drive_a) a++;
      if (drive_b) b++;
      n++;
      @(negedge clk);
    end while (!period_start && n < 70000);
    check(b == 30 - 5 + 5 || b == 30, "R8 old word kept in running period", b, 30);
    measure(n, a, b);
    check(a == 10, "R8 new word in next period", a, 10);

    // R9: disable mid-run, then first pulse goes to A again
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    busy = 0;
    for (int i = 0; i < 10; i++) begin
      if (drive_a || drive_b || period_start) busy++;
      @(negedge clk);
    end
    check(busy == 0, "R9 outputs low after disable", busy, 0);
    run_cfg(20, 4, 0, 0, 1'b0, 2, "R9 restart on A");

    // R9: reset during run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(!drive_a && !drive_b && !period_start, "R9 reset mid-run", {drive_a, drive_b, period_start}, 0);
    rst = 1'b0;

    // random configurations
    for (int r = 0; r < 8; r++) begin
      int p, ca, cb, dt;
      p  = 8 + int'($urandom % 50);
      ca = int'($urandom % (p + 4));
      cb = int'($urandom % (p + 4));
      dt = int'($urandom % 12);
      run_cfg(p, ca, cb, dt, r[0], 3, "R2 random");
    end

    // R10 strobe cycle blank, checked on a live run
    start(25, 0, 0, 0, 1'b1);
    check(!drive_a && !drive_b, "R10 blank at strobe", {drive_a, drive_b}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule